// File: doc/BRIEF.md
# Right-Justified Stereo DAC Serializer

This block turns a pair of signed parallel samples (one left, one right) into a single serial data stream for a stereo digital-to-analog converter. It also drives the bit clock and the channel-select (LR) line. Each channel owns a half-frame of `HALF_CYC` bit-clock cycles, and the sample sits at the right-hand end of it. The half-frame opens with zero padding. The sample then goes out most significant bit first, so its least significant bit occupies the last cycle before LR changes. All outputs change together with the falling edge of the bit clock, which lets the converter sample on the rising edge.

The bit clock can come from either of two sources, chosen at elaboration:
- an internal divider of the system clock, or
- an external bit clock, which the block synchronizes and follows.

The block takes a new stereo pair once per frame, at the edge that opens the left half-frame. At that moment it raises a one-cycle ready strobe so the producer knows to present the next pair. Reset clears the datapath and parks the frame position at the first cycle of the left half-frame, while the bit clock keeps toggling.

With the default parameters (18-bit samples, 32-cycle half-frames) there are 14 padding cycles ahead of the sign bit.

Top module: `rj_dac_serializer`

## Requirements
- R1: With the internal divider, every high and every low level of `bclk_o` lasts exactly `DIV_HALF` clock cycles, and the toggling continues while `rst_n` is low.
- R2: `lrck_o` changes only in the clock cycle where `bclk_o` falls, once every `HALF_CYC` bit-clock cycles; it is 1 for the left half-frame and 0 for the right half-frame.
- R3: During bit cycles 1 to `HALF_CYC-SAMPLE_W` (cycles 1..14 by default) of each half-frame, counted from the LR change, `sdata_o` is 0.
- R4: During bit cycles `HALF_CYC-SAMPLE_W+1` to `HALF_CYC` (15..32), `sdata_o` carries that half-frame's two's-complement sample MSB first. The sign bit is on cycle 15 and the LSB is on cycle 32, just before the LR change. The left half carries `left_i` and the right half carries `right_i`.
- R5: `sdata_o` changes only in a clock cycle where `bclk_o` falls.
- R6: The pair on `left_i`/`right_i` is captured only at the falling bit-clock edge that opens a left half-frame, and both channels of the frame that follows use that pair. Input changes at any other time have no effect on the frame in progress.
- R7: `ready_o` is a pulse one clock wide, raised exactly in the cycle where `lrck_o` rises.
- R8: While `rst_n` (synchronous, active low) is low, `sdata_o` is 0, `lrck_o` is 1, `ready_o` is 0 and the position is bit cycle 1 of the left half-frame. The first falling edge after release moves to cycle 2. The captured pair resets to zero, so the first frame after reset sends zeros.
- R9: With `EXT_BCLK=1`, the bit clock comes from `bclk_ext_i` through `SYNC_STAGES` synchronizer flops and one output flop. All outputs then follow the same timeline as the internal mode driven by that clock, delayed by `SYNC_STAGES+1` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the datapath and frame position |
| bclk_ext_i | input | 1 | External bit clock, used only when `EXT_BCLK=1` |
| left_i | input | SAMPLE_W | Left-channel signed sample |
| right_i | input | SAMPLE_W | Right-channel signed sample |
| bclk_o | output | 1 | Bit clock to the converter |
| lrck_o | output | 1 | Channel select: 1 = left, 0 = right |
| sdata_o | output | 1 | Serial data, right-justified, MSB first |
| ready_o | output | 1 | One-cycle strobe as a pair is captured; request for the next pair |

## Verification
The embedded properties check four things on every cycle:
- LR and serial data move only with a falling bit-clock edge.
- The padding cycles of each half-frame carry zero.
- The ready strobe is one cycle wide and coincides with the rising edge of LR.

Some behaviour only the bench's scenarios can show:
- the actual bit order of each sample, including the sign and LSB positions at the extreme values;
- that inputs scribbled over during a frame are ignored;
- the reset position, and the first zero frame after release;
- the exact divider period;
- the follow mode's fixed lag behind the internal timeline.

// File: rtl/rjs_pkg.sv
package rjs_pkg;

   // Level driven on the channel-select line for each half-frame.
   typedef enum logic {
      CH_RIGHT = 1'b0,
      CH_LEFT  = 1'b1
   } chan_e;

   // Width of a counter that must hold values 0 .. n-1 (at least one bit).
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rjs_bclk_src.sv
// Bit-clock source: the internal divider or a synchronized external clock.
// Produces a registered bit clock and a strobe for the cycle in which it falls.
module rjs_bclk_src #(
   parameter int DIV_HALF    = 4,
   parameter bit EXT_BCLK    = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic bclk_ext_i,
   output logic bclk_o,
   output logic fall_o
);
   import rjs_pkg::*;

   localparam int DW = cnt_width(DIV_HALF);

   logic bclk_q;

   generate
      if (EXT_BCLK) begin : g_follow
         logic [SYNC_STAGES-1:0] sync_q;

         // Free-running: the synchronizer needs no reset.
         always_ff @(posedge clk) begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], bclk_ext_i};
            bclk_q <= sync_q[SYNC_STAGES-1];
         end

         assign fall_o = bclk_q & ~sync_q[SYNC_STAGES-1];
      end else begin : g_divide
         localparam logic [DW-1:0] LIM = DW'(DIV_HALF - 1);

         logic [DW-1:0] div_q;
         logic          wrap;

         assign wrap = (div_q >= LIM);

         // Free-running: the bit clock keeps toggling through reset.
         always_ff @(posedge clk) begin
            if (wrap) begin
               div_q  <= '0;
               bclk_q <= ~bclk_q;
            end else begin
               div_q  <= div_q + DW'(1);
            end
         end

         assign fall_o = wrap & bclk_q;

         logic unused_ext;
         assign unused_ext = bclk_ext_i;
      end
   endgenerate

   assign bclk_o = bclk_q;

endmodule

// File: rtl/rjs_frame_ctr.sv
// Half-frame position counter and channel select, stepped on falling bit-clock edges.
module rjs_frame_ctr #(
   parameter int HALF_CYC = 32,
   parameter int CNT_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             lr_o,
   output logic             lr_nxt_o,
   output logic             frame_start_o,
   output logic             ready_o
);
   import rjs_pkg::*;

   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   chan_e            lr_q;
   logic             rdy_q;
   logic             at_last;

   assign at_last       = (cnt_q == LAST);
   assign cnt_nxt_o     = step_i ? (at_last ? '0 : cnt_q + CNT_W'(1)) : cnt_q;
   assign lr_nxt_o      = (step_i && at_last) ? ~lr_q : lr_q;
   assign frame_start_o = step_i && at_last && (lr_q == CH_RIGHT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lr_q  <= CH_LEFT;
         rdy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt_o;
         lr_q  <= chan_e'(lr_nxt_o);
         rdy_q <= frame_start_o;
      end
   end

   assign cnt_o   = cnt_q;
   assign lr_o    = lr_q;
   assign ready_o = rdy_q;

   // R2: the channel may only flip after the last cycle of a half-frame.
   p_flip_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lr_q != $past(lr_q)) |-> (cnt_q == '0 && $past(cnt_q) == LAST));

endmodule

// File: rtl/rjs_word_shift.sv
// Pair capture and right-justified MSB-first shifter with a registered data output.
module rjs_word_shift #(
   parameter int SAMPLE_W = 18,
   parameter int HALF_CYC = 32,
   parameter int CNT_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step_i,
   input  logic [CNT_W-1:0]    cnt_i,
   input  logic [CNT_W-1:0]    cnt_nxt_i,
   input  logic                lr_nxt_i,
   input  logic                frame_start_i,
   input  logic [SAMPLE_W-1:0] left_i,
   input  logic [SAMPLE_W-1:0] right_i,
   output logic                sdata_o
);
   localparam int               PAD   = HALF_CYC - SAMPLE_W;
   localparam logic [CNT_W-1:0] LOADP = CNT_W'(PAD);

   logic [SAMPLE_W-1:0] lat_l_q, lat_r_q, sh_q;
   logic [SAMPLE_W-1:0] left_word, word;
   logic                sd_q;

   generate
      if (PAD == 0) begin : g_no_pad
         // The sign bit lands in the capture cycle; bypass the latch.
         assign left_word = frame_start_i ? left_i : lat_l_q;
      end else begin : g_pad
         assign left_word = lat_l_q;
      end
   endgenerate

   assign word = lr_nxt_i ? left_word : lat_r_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_l_q <= '0;
         lat_r_q <= '0;
         sh_q    <= '0;
         sd_q    <= 1'b0;
      end else begin
         if (frame_start_i) begin
            lat_l_q <= left_i;
            lat_r_q <= right_i;
         end
         if (step_i) begin
            if (cnt_nxt_i == LOADP) begin
               sd_q <= word[SAMPLE_W-1];
               sh_q <= word << 1;
            end else if (cnt_nxt_i > LOADP) begin
               sd_q <= sh_q[SAMPLE_W-1];
               sh_q <= sh_q << 1;
            end else begin
               sd_q <= 1'b0;
            end
         end
      end
   end

   assign sdata_o = sd_q;

   generate
      if (PAD > 0) begin : g_pad_chk
         // R3: the padding cycles of every half-frame carry zero.
         p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_i < LOADP) |-> (sd_q == 1'b0));
      end
   endgenerate

endmodule

// File: rtl/rj_dac_serializer.sv
// Right-justified stereo serializer: bit clock, channel select, serial data, pair request.
module rj_dac_serializer #(
   parameter int SAMPLE_W    = 18,
   parameter int HALF_CYC    = 32,
   parameter int DIV_HALF    = 4,
   parameter bit EXT_BCLK    = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_ext_i,
   input  logic [SAMPLE_W-1:0] left_i,
   input  logic [SAMPLE_W-1:0] right_i,
   output logic                bclk_o,
   output logic                lrck_o,
   output logic                sdata_o,
   output logic                ready_o
);
   import rjs_pkg::*;

   localparam int CNT_W = cnt_width(HALF_CYC);

   generate
      if (SAMPLE_W < 1 || SAMPLE_W > HALF_CYC) begin : g_bad_width
         $error("SAMPLE_W must lie in 1..HALF_CYC");
      end
      if (HALF_CYC < 2) begin : g_bad_half
         $error("HALF_CYC must be at least 2");
      end
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (EXT_BCLK && SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2 in follow mode");
      end
   endgenerate

   logic             fall;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             lr_nxt, frame_start;

   rjs_bclk_src #(
      .DIV_HALF   (DIV_HALF),
      .EXT_BCLK   (EXT_BCLK),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_src (
      .clk       (clk),
      .bclk_ext_i(bclk_ext_i),
      .bclk_o    (bclk_o),
      .fall_o    (fall)
   );

   rjs_frame_ctr #(
      .HALF_CYC(HALF_CYC),
      .CNT_W   (CNT_W)
   ) u_ctr (
      .clk          (clk),
      .rst_n        (rst_n),
      .step_i       (fall),
      .cnt_o        (cnt),
      .cnt_nxt_o    (cnt_nxt),
      .lr_o         (lrck_o),
      .lr_nxt_o     (lr_nxt),
      .frame_start_o(frame_start),
      .ready_o      (ready_o)
   );

   rjs_word_shift #(
      .SAMPLE_W(SAMPLE_W),
      .HALF_CYC(HALF_CYC),
      .CNT_W   (CNT_W)
   ) u_shf (
      .clk          (clk),
      .rst_n        (rst_n),
      .step_i       (fall),
      .cnt_i        (cnt),
      .cnt_nxt_i    (cnt_nxt),
      .lr_nxt_i     (lr_nxt),
      .frame_start_i(frame_start),
      .left_i       (left_i),
      .right_i      (right_i),
      .sdata_o      (sdata_o)
   );

   // R2: channel select moves only together with a falling bit-clock edge.
   p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lrck_o != $past(lrck_o)) |-> (!bclk_o && $past(bclk_o)));

   // R5: serial data moves only together with a falling bit-clock edge.
   p_data_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sdata_o != $past(sdata_o)) |-> (!bclk_o && $past(bclk_o)));

   // R7: the request strobe is a single cycle wide.
   p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !ready_o);

   // R7: the request strobe coincides with the start of a left half-frame.
   p_ready_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lrck_o) |-> ready_o);

   p_ready_is_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (lrck_o && !$past(lrck_o)));

endmodule

// File: tb/sim_rj_dac_serializer.sv
module sim_rj_dac_serializer;
   localparam int SW   = 18;
   localparam int HC   = 32;
   localparam int DIVH = 4;
   localparam int SYN  = 2;
   localparam int DLY  = SYN + 1;
   localparam int PADN = HC - SW;

   logic clk = 1'b0;
   always #5 clk = ~clk;   // 100 MHz

   logic          rst_n = 1'b0;
   logic [SW-1:0] l_in  = '0;
   logic [SW-1:0] r_in  = '0;

   logic bclk0, lr0, sd0, rdy0;
   logic bclk1, lr1, sd1, rdy1;

   rj_dac_serializer #(.SAMPLE_W(SW), .HALF_CYC(HC), .DIV_HALF(DIVH),
                       .EXT_BCLK(1'b0), .SYNC_STAGES(SYN)) u0 (
      .clk(clk), .rst_n(rst_n), .bclk_ext_i(1'b0),
      .left_i(l_in), .right_i(r_in),
      .bclk_o(bclk0), .lrck_o(lr0), .sdata_o(sd0), .ready_o(rdy0));

   rj_dac_serializer #(.SAMPLE_W(SW), .HALF_CYC(HC), .DIV_HALF(DIVH),
                       .EXT_BCLK(1'b1), .SYNC_STAGES(SYN)) u1 (
      .clk(clk), .rst_n(rst_n), .bclk_ext_i(bclk0),
      .left_i(l_in), .right_i(r_in),
      .bclk_o(bclk1), .lrck_o(lr1), .sdata_o(sd1), .ready_o(rdy1));

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Values present at the last rising edge.
   logic          rs_q = 1'b0;
   logic [SW-1:0] lq = '0, rq = '0;
   always @(posedge clk) begin
      rs_q <= rst_n;
      lq   <= l_in;
      rq   <= r_in;
   end

   // Behavioural reference for u0.
   int            m_pos = 1;
   logic          m_lr  = 1'b1;
   logic [SW-1:0] m_l = '0, m_r = '0;
   logic          b_prev  = 1'b0;
   logic          sd_prev = 1'b0;
   int            lvl_cnt = 0;
   int            lvl_seen = 0;
   logic [3:0]    hist[$];

   always @(negedge clk) begin
      logic          exp_rdy, exp_sd, fell;
      logic [SW-1:0] w;
      fell    = b_prev && !bclk0;
      exp_rdy = 1'b0;
      if (!rs_q) begin
         m_pos = 1; m_lr = 1'b1; m_l = '0; m_r = '0;
      end else if (fell) begin
         if (m_pos == HC) begin
            m_pos = 1;
            m_lr  = !m_lr;
            if (m_lr) begin
               m_l = lq; m_r = rq; exp_rdy = 1'b1;
            end
         end else begin
            m_pos++;
         end
      end
      w      = m_lr ? m_l : m_r;
      exp_sd = (m_pos <= PADN) ? 1'b0 : w[SW-1-(m_pos-PADN-1)];

      if (!rs_q) begin
         chk("R8 data in reset", 32'(sd0), 32'(0));
         chk("R8 lr in reset", 32'(lr0), 32'(1));
         chk("R8 ready in reset", 32'(rdy0), 32'(0));
      end else begin
         chk("R2 lr", 32'(lr0), 32'(m_lr));
         if (m_pos <= PADN) chk("R3 pad data", 32'(sd0), 32'(exp_sd));
         else               chk("R4 sample bit", 32'(sd0), 32'(exp_sd));
         chk("R7 ready", 32'(rdy0), 32'(exp_rdy));
         if (sd0 != sd_prev) chk("R5 data moved without fall", 32'(fell), 32'(1));
      end

      // R1: level lengths of the internal bit clock, reset or not.
      if (bclk0 != b_prev) begin
         if (lvl_seen > 1) chk("R1 bclk level length", 32'(lvl_cnt), 32'(DIVH));
         lvl_seen++;
         lvl_cnt = 1;
      end else begin
         lvl_cnt++;
      end

      // R9: follow mode trails the internal timeline by DLY cycles.
      hist.push_back({bclk0, lr0, sd0, rdy0});
      if (hist.size() > DLY + 1) void'(hist.pop_front());
      if (hist.size() == DLY + 1 && rs_q && $time > 200)
         chk("R9 follow mode", 32'({bclk1, lr1, sd1, rdy1}), 32'(hist[0]));

      b_prev  = bclk0;
      sd_prev = sd0;
   end

   function automatic logic [SW-1:0] pat(input int f, input bit right);
      logic [SW-1:0] v;
      case (f)
         0: v = right ? 18'h20000 : 18'h1FFFF;
         1: v = right ? 18'h00001 : 18'h3FFFF;
         2: v = right ? 18'h15555 : 18'h2AAAA;
         3: v = right ? 18'h3FFFF : 18'h00000;
         default: v = SW'((f * 40503 + (right ? 977 : 12345)) * 2654435 >> 7);
      endcase
      return v;
   endfunction

   task automatic release_aligned();
      @(posedge bclk0);
      #2 rst_n = 1'b1;
   endtask

   task automatic run_frames(input int first, input int cnt);
      for (int f = first; f < first + cnt; f++) begin
         @(posedge rdy1);
         #2;
         l_in = 18'h2D2D2;   // scribble: must not reach the output (R6)
         r_in = 18'h1B1B1;
         repeat (300) @(posedge clk);
         #2;
         l_in = pat(f, 1'b0);
         r_in = pat(f, 1'b1);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20) @(posedge clk);
      #2;
      l_in = pat(0, 1'b0);
      r_in = pat(0, 1'b1);
      release_aligned();
      run_frames(1, 8);
      @(posedge clk);
      #2 rst_n = 1'b0;
      repeat (300) @(posedge clk);
      #2;
      l_in = pat(9, 1'b0);
      r_in = pat(9, 1'b1);
      release_aligned();
      run_frames(10, 4);
      repeat (600) @(posedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      finish_run();
   end

endmodule